// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block accepts interrupts for a small 8-bit accumulator processor. It latches one non-maskable request and eight maskable requests, each on its rising edge. When the core raises its instruction-boundary strobe, the block decides whether an interrupt should be taken. If one is taken, it runs a fixed-length entry sequence. The sequence pushes the register context onto a stack that grows downward, sets the interrupt-mask flag and reads the handler address from the winning source's vector. The block drives a simple synchronous byte port for all of this: a write takes effect at the clock edge, and read data arrives one cycle after the address.

On leaving reset the block runs a short boot sequence. It fetches the start address from the reset vector and hands back a stack pointer at the top of its masked range and a condition-code value with only the mask flag set. The core then clears its own accumulator and index register. Both sequences end with a one-cycle `done` pulse, and the new program counter, stack pointer and condition codes are valid in that cycle.

The state machine has eleven states:

| State | What happens | Next state |
|-------|--------------|------------|
| S_IDLE | Waits. Goes to S_PCL when the strobe and a takeable request meet. | S_PCL |
| S_PCL | Pushes the low byte of the program counter. | S_PCH |
| S_PCH | Pushes the high byte of the program counter. | S_X |
| S_X | Pushes X. | S_A |
| S_A | Pushes A. | S_CC |
| S_CC | Pushes CC. | S_VHI |
| S_VHI | Issues the read of the vector high byte. | S_VLO |
| S_VLO | Issues the read of the vector low byte and captures the high byte. | S_VCAP |
| S_VCAP | Captures the low byte. Goes to S_DONE in the boot sequence, otherwise to S_PAD. | S_DONE or S_PAD |
| S_PAD | Stays for the padding cycles. | S_DONE |
| S_DONE | Pulses `done`. | S_IDLE |

Reset places the machine in S_VHI, with the reset vector selected.

Top module: `irq_entry_seq`

## Requirements
- R1: Reset clears all pending bits. In the first cycle after reset is released the block reads 0x1FFE; in the second cycle it reads 0x1FFF. The fourth cycle carries `done`, with `new_pc` = {byte@0x1FFE, byte@0x1FFF}, `new_sp` = SP_MASK and `new_cc` = 0x08.
- R2: A request becomes pending on its rising edge and stays pending whatever the line does afterwards, until that interrupt is taken. A line held high is taken only once. If a new rising edge arrives in the same cycle as the take, the request stays pending.
- R3: Requests are evaluated only in S_IDLE, and only in a cycle with `boundary` high. A strobe seen while `busy` is ignored. A request that arrives during an entry is taken at a later boundary.
- R4: A pending non-maskable request wins over every maskable one. It is taken even when CC bit 3 (I) is set, and its vector is 0x1FFC.
- R5: A maskable request is taken only when `cur_cc` bit 3 is clear at the boundary. While bit 3 is set it stays pending.
- R6: Maskable lines `irq_req[0..7]` have priority from index 0 (highest) to 7 (lowest). Their vectors, in index order, are 0x1FF8, 0x1FEC, 0x1FEA, 0x1FF6, 0x1FF4, 0x1FF2, 0x1FF0 and 0x1FEE.
- R7: In entry cycles 1 to 5 the block writes PC[7:0], PC[15:8], X, A and CC, in that order. The addresses are SP, SP-1, SP-2, SP-3 and SP-4, where SP is `cur_sp` at the boundary and decrementing wraps within SP_MASK.
- R8: The block reads the vector high byte at the vector address in cycle 6 and the low byte at the vector address + 1 in cycle 7. Data returns one cycle after the address.
- R9: An entry keeps `busy` high for exactly 11 cycles after the accepting edge. `done` is high only in the last of them, for one cycle.
- R10: In the `done` cycle of an entry, `new_cc` = the saved CC with bit 3 set and `new_sp` = SP-5 (masked wrap).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request line |
| irq_req | input | 8 | Maskable request lines, index 0 highest |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| cur_pc | input | 16 | Program counter to save |
| cur_x | input | 8 | Index register to save |
| cur_a | input | 8 | Accumulator to save |
| cur_cc | input | 8 | Condition codes to save; bit 3 is I |
| cur_sp | input | 16 | Stack pointer at entry |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| new_pc | output | 16 | Handler or start address |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_cc | output | 8 | Condition codes with I set |

## Verification
The bench builds the block with its defaults: ENTRY_CYCLES = 11, SP_MASK = 0x00FF and I_BIT = 3. The stack range is only 256 bytes, so starting an entry at SP = 0x0002 pushes across the wrap to 0x00FF within a single sequence. Eleven-cycle entries keep strobes held through `busy`, and late requests during an entry, within a few cycles of the boundary. Simultaneous requests, a masked CC, a non-maskable request in front of pending maskable ones, and a re-edge in the take cycle are each driven once.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int NUM_MSK = 8;
    localparam logic [15:0] VEC_NMI = 16'h1FFC;
    localparam logic [15:0] VEC_RST = 16'h1FFE;

    typedef enum logic [3:0] {
        S_IDLE, S_PCL, S_PCH, S_X, S_A, S_CC,
        S_VHI, S_VLO, S_VCAP, S_PAD, S_DONE
    } seq_state_t;

    // fixed, irregular priority-to-vector map (index 0 = highest priority)
    function automatic logic [15:0] msk_vector(input int idx);
        case (idx)
            0:       return 16'h1FF8;
            1:       return 16'h1FEC;
            2:       return 16'h1FEA;
            3:       return 16'h1FF6;
            4:       return 16'h1FF4;
            5:       return 16'h1FF2;
            6:       return 16'h1FF0;
            default: return 16'h1FEE;
        endcase
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev[i] <= 1'b0;
                pend[i] <= 1'b0;
            end else begin
                prev[i] <= req[i];
                // a new edge in the take cycle wins over the clear
                pend[i] <= (pend[i] && !clr[i]) || (req[i] && !prev[i]);
            end
        end

        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]); // R2
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_seq_pkg::*;
#(
    parameter int N = NUM_MSK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic         enable,
    output logic         any,
    output logic [N-1:0] grant,
    output logic [15:0]  vector
);

    always_comb begin
        grant  = '0;
        vector = VEC_NMI;
        for (int i = N - 1; i >= 0; i--) begin
            if (enable && pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vector   = msk_vector(i);
            end
        end
    end

    assign any = |grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pend) == '0)); // R2

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          ENTRY_CYCLES = 11,
    parameter logic [15:0] SP_MASK      = 16'h00FF,
    parameter int          I_BIT        = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nmi_req,
    input  logic [7:0]  irq_req,
    input  logic        boundary,
    input  logic [15:0] cur_pc,
    input  logic [7:0]  cur_x,
    input  logic [7:0]  cur_a,
    input  logic [7:0]  cur_cc,
    input  logic [15:0] cur_sp,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] new_pc,
    output logic [15:0] new_sp,
    output logic [7:0]  new_cc
);

    // five pushes, three vector cycles and the done cycle are fixed
    localparam int PAD_CYCLES = ENTRY_CYCLES - 9;
    localparam int PADW       = $clog2(PAD_CYCLES + 1);
    localparam logic [7:0] I_MASK = 8'(1 << I_BIT);

    seq_state_t state, state_nx;

    logic [PADW-1:0] pad_cnt;
    logic            rst_flag;
    logic [15:0]     ctx_pc, ctx_sp, vec;
    logic [7:0]      ctx_x, ctx_a, ctx_cc, pc_hi, pc_lo;

    logic            nmi_pend;
    logic [NUM_MSK-1:0] msk_pend, msk_grant, msk_clr;
    logic            msk_any;
    logic [15:0]     msk_vec;
    logic            take_nmi, take_msk, take;
    logic [15:0]     sp_dec;

    irq_pend_latch #(.N(1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .req(nmi_req), .clr(take_nmi), .pend(nmi_pend)
    );

    irq_pend_latch #(.N(NUM_MSK)) u_msk (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(msk_clr), .pend(msk_pend)
    );

    irq_prio_pick #(.N(NUM_MSK)) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(msk_pend), .enable(!cur_cc[I_BIT]),
        .any(msk_any), .grant(msk_grant), .vector(msk_vec)
    );

    assign take_nmi = (state == S_IDLE) && boundary && nmi_pend;
    assign take_msk = (state == S_IDLE) && boundary && !nmi_pend && msk_any;
    assign take     = take_nmi || take_msk;
    assign msk_clr  = take_msk ? msk_grant : '0;
    assign sp_dec   = ((ctx_sp - 16'd1) & SP_MASK) | (ctx_sp & ~SP_MASK);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: state_nx = take ? S_PCL : S_IDLE;
            S_PCL:  state_nx = S_PCH;
            S_PCH:  state_nx = S_X;
            S_X:    state_nx = S_A;
            S_A:    state_nx = S_CC;
            S_CC:   state_nx = S_VHI;
            S_VHI:  state_nx = S_VLO;
            S_VLO:  state_nx = S_VCAP;
            S_VCAP: state_nx = rst_flag ? S_DONE : S_PAD;
            S_PAD:  state_nx = (pad_cnt == PADW'(PAD_CYCLES - 1)) ? S_DONE : S_PAD;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register and context datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_VHI;
            rst_flag <= 1'b1;
            vec      <= VEC_RST;
            ctx_sp   <= SP_MASK;
            ctx_pc   <= '0;
            ctx_x    <= '0;
            ctx_a    <= '0;
            ctx_cc   <= '0;
            pc_hi    <= '0;
            pc_lo    <= '0;
            pad_cnt  <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                S_IDLE: begin
                    pad_cnt <= '0;
                    if (take) begin
                        rst_flag <= 1'b0;
                        ctx_pc   <= cur_pc;
                        ctx_x    <= cur_x;
                        ctx_a    <= cur_a;
                        ctx_cc   <= cur_cc;
                        ctx_sp   <= cur_sp;
                        vec      <= take_nmi ? VEC_NMI : msk_vec;
                    end
                end
                S_PCL, S_PCH, S_X, S_A, S_CC: ctx_sp <= sp_dec;
                S_VLO:  pc_hi   <= mem_rdata;
                S_VCAP: pc_lo   <= mem_rdata;
                S_PAD:  pad_cnt <= pad_cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = ctx_sp;
        mem_wdata = '0;
        unique case (state)
            S_PCL: begin mem_we = 1'b1; mem_wdata = ctx_pc[7:0];  end
            S_PCH: begin mem_we = 1'b1; mem_wdata = ctx_pc[15:8]; end
            S_X:   begin mem_we = 1'b1; mem_wdata = ctx_x;        end
            S_A:   begin mem_we = 1'b1; mem_wdata = ctx_a;        end
            S_CC:  begin mem_we = 1'b1; mem_wdata = ctx_cc;       end
            S_VHI: begin mem_re = 1'b1; mem_addr = vec;           end
            S_VLO: begin mem_re = 1'b1; mem_addr = vec + 16'd1;   end
            default: ;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign done   = (state == S_DONE);
    assign new_pc = {pc_hi, pc_lo};
    assign new_sp = ctx_sp;
    assign new_cc = ctx_cc | I_MASK;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_CC_I: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_cc[I_BIT]); // R10
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        ((mem_addr & SP_MASK) == (($past(mem_addr) - 16'd1) & SP_MASK))); // R7
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R3

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        boundary = 1'b0;
    logic [15:0] cur_pc = 16'h1234;
    logic [7:0]  cur_x = 8'h56, cur_a = 8'h78, cur_cc = 8'h00;
    logic [15:0] cur_sp = 16'h00FF;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re, busy, done;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] new_pc, new_sp;
    logic [7:0]  new_cc;

    always #5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .boundary(boundary), .cur_pc(cur_pc), .cur_x(cur_x), .cur_a(cur_a),
        .cur_cc(cur_cc), .cur_sp(cur_sp), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .new_pc(new_pc), .new_sp(new_sp), .new_cc(new_cc)
    );

    function automatic logic [7:0] vb(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] vtab(input int i);
        case (i)
            0: return 16'h1FF8; 1: return 16'h1FEC; 2: return 16'h1FEA;
            3: return 16'h1FF6; 4: return 16'h1FF4; 5: return 16'h1FF2;
            6: return 16'h1FF0; default: return 16'h1FEE;
        endcase
    endfunction

    // synchronous memory: data one cycle after the address
    always @(posedge clk) if (mem_re) mem_rdata <= vb(mem_addr);

    int nchk = 0, nfail = 0;
    bit finished = 0;
    string scen = "R1";

    // behavioural reference
    int         mph;
    bit         mrst, mnmi, mprevn;
    logic [7:0] mpend, mprev, cc0, x0, a0;
    logic [15:0] pc0, sp0, vec;

    function automatic logic [15:0] spm(input logic [15:0] s, input int k);
        return (s - 16'(k)) & 16'h00FF;
    endfunction

    task automatic model_reset();
        mph = 1; mrst = 1; mnmi = 0; mprevn = 0; mpend = 0; mprev = 0;
        vec = 16'h1FFE; sp0 = 16'h00FF; cc0 = 0; pc0 = 0; x0 = 0; a0 = 0;
    endtask

    task automatic model_next();
        bit tk = 0;
        if (mph == 0 && boundary) begin
            if (mnmi) begin
                tk = 1; mnmi = 0; vec = 16'h1FFC;
            end else if (mpend != 0 && !cur_cc[3]) begin
                for (int i = 7; i >= 0; i--)
                    if (mpend[i]) vec = vtab(i);
                for (int i = 0; i < 8; i++)
                    if (mpend[i]) begin mpend[i] = 0; break; end
                tk = 1;
            end
            if (tk) begin
                mph = 1; mrst = 0; pc0 = cur_pc; x0 = cur_x; a0 = cur_a;
                cc0 = cur_cc; sp0 = cur_sp;
            end
        end else if (mph != 0) begin
            mph = (mph == (mrst ? 4 : 11)) ? 0 : mph + 1;
        end
        if (nmi_req && !mprevn) mnmi = 1;
        mprevn = nmi_req;
        mpend  = mpend | (irq_req & ~mprev);
        mprev  = irq_req;
    endtask

    task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s (%s): actual %h expected %h", what, scen, got, exp);
        end
    endtask

    task automatic compare();
        bit eb, ed, ewe, ere;
        logic [15:0] ea;
        logic [7:0] ewd;
        eb = (mph != 0);
        ed = mrst ? (mph == 4) : (mph == 11);
        ewe = 0; ere = 0; ea = 0; ewd = 0;
        if (mrst) begin
            if (mph == 1) begin ere = 1; ea = vec; end
            if (mph == 2) begin ere = 1; ea = vec + 1; end
        end else if (mph >= 1 && mph <= 5) begin
            ewe = 1; ea = spm(sp0, mph - 1);
            case (mph)
                1: ewd = pc0[7:0]; 2: ewd = pc0[15:8]; 3: ewd = x0;
                4: ewd = a0; default: ewd = cc0;
            endcase
        end else if (mph == 6) begin ere = 1; ea = vec; end
        else if (mph == 7) begin ere = 1; ea = vec + 1; end
        chk("R9 busy", 16'(busy), 16'(eb));
        chk("R9 done", 16'(done), 16'(ed));
        chk("R7 write strobe", 16'(mem_we), 16'(ewe));
        chk("R8 read strobe", 16'(mem_re), 16'(ere));
        if (ewe) begin
            chk("R7 push address", mem_addr, ea);
            chk("R7 push data", 16'(mem_wdata), 16'(ewd));
        end
        if (ere) chk("R8 vector address", mem_addr, ea);
        if (ed) begin
            chk("R8 new_pc", new_pc, {vb(vec), vb(vec + 1)});
            chk("R10 new_sp", new_sp, mrst ? 16'h00FF : spm(sp0, 5));
            chk("R10 new_cc", 16'(new_cc), 16'(cc0 | 8'h08));
        end
    endtask

    task automatic tick();
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic strobe();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic pulse_irq(int i);
        irq_req[i] = 1; tick(); irq_req[i] = 0; tick();
    endtask

    initial begin
        // R1: reset sequence
        scen = "R1";
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare();
        ticks(6);

        // R6: single source
        scen = "R6";
        pulse_irq(3);
        strobe(); ticks(13);

        // R6: three at once, lowest index wins each time
        scen = "R6";
        irq_req = 8'b1010_0100; tick(); irq_req = 0; tick();
        cur_pc = 16'hBEEF; cur_cc = 8'h05;
        strobe(); ticks(13);
        strobe(); ticks(13);
        strobe(); ticks(13);

        // R5: masked request waits until I clears
        scen = "R5";
        cur_cc = 8'h08;
        pulse_irq(0);
        strobe(); ticks(4);
        cur_cc = 8'h02;
        strobe(); ticks(13);

        // R4: non-maskable ahead of pending maskable, I set
        scen = "R4";
        cur_cc = 8'h08;
        pulse_irq(1);
        nmi_req = 1; tick(); nmi_req = 0; tick();
        strobe(); ticks(13);
        cur_cc = 8'h00;
        strobe(); ticks(13);

        // R3: request during entry, strobe held through busy
        scen = "R3";
        pulse_irq(6);
        boundary = 1; tick();
        irq_req[7] = 1; tick(); irq_req[7] = 0;
        ticks(14);
        boundary = 0; ticks(13);

        // R2: held line taken once
        scen = "R2";
        irq_req[4] = 1; tick();
        strobe(); ticks(13);
        strobe(); ticks(3);
        irq_req[4] = 0; tick();

        // R2: new edge in the take cycle keeps it pending
        scen = "R2";
        pulse_irq(5);
        irq_req[5] = 1; boundary = 1; tick(); boundary = 0; irq_req[5] = 0;
        ticks(13);
        strobe(); ticks(13);

        // R7/R10: stack wrap within the mask
        scen = "R7";
        cur_sp = 16'h0002; cur_x = 8'hC3; cur_a = 8'h3C;
        pulse_irq(2);
        strobe(); ticks(13);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog (%s): actual hung expected finished", scen);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule